// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides where each of the two ALU operands of a five-stage integer pipeline comes from while the consuming instruction is in the execute stage. It compares the two source register numbers of that instruction against the destination register numbers of the two older instructions further down the pipe. These are the one just past execute, called the memory-side stage here, and the one about to write back, called the writeback-side stage. Each of those older instructions comes with a register-write flag. From these comparisons the block produces one 2-bit select per operand and applies that select to a 4-way data mux.

The unit is purely combinational. It has no clock, no reset and no storage. The pipeline registers feed it directly, and its operand outputs go straight to the ALU inputs. Register zero is hard-wired to zero in the architecture, so it is never taken from a later stage. When both older instructions target the same source register, the younger one (the memory-side stage) is chosen, because it holds the most recent value.

Select encoding: `00` passes the register-file read value, `01` passes the writeback-side result, `10` passes the memory-side result. The code `11` is never generated; if it reaches the mux it behaves like `00`.

Top module: `opfwd_unit`

## Requirements
- R1: When `exm_wr_en` is 1, `exm_rd` is nonzero and `exm_rd` equals `src_a`, `sel_a` is `10` and `opnd_a` equals `exm_result`.
- R2: When `exm_wr_en` is 1, `exm_rd` is nonzero and `exm_rd` equals `src_b`, `sel_b` is `10` and `opnd_b` equals `exm_result`.
- R3: When `mwb_wr_en` is 1, `mwb_rd` is nonzero, `mwb_rd` equals an operand's source, and the R1/R2 condition for that operand is false, that operand's select is `01` and its output equals `mwb_result`.
- R4: When both later stages satisfy their forwarding conditions for the same operand, the memory-side result (`10`) is chosen over the writeback-side result.
- R5: A source register number of zero never selects a forwarded value: the select is `00` and the output equals the register-file value.
- R6: A stage whose write flag is 0 never supplies a forwarded value, whatever its destination number.
- R7: With no forwarding condition true for an operand, its select is `00` and its output equals its register-file read value.
- R8: Operand A is decided only from `src_a` and operand B only from `src_b`; neither decision depends on the other source.
- R9: Neither select output ever carries the code `11`.
- R10: Over a stream of back-to-back dependent instructions in a three-deep execute/memory/writeback pipe, the forwarded operands produce the same results as strictly sequential execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | REG_AW | Source register number of operand A in execute |
| src_b | input | REG_AW | Source register number of operand B in execute |
| rf_val_a | input | DATA_W | Register-file read value for operand A |
| rf_val_b | input | DATA_W | Register-file read value for operand B |
| exm_wr_en | input | 1 | Memory-side stage will write a register |
| exm_rd | input | REG_AW | Memory-side stage destination register |
| exm_result | input | DATA_W | Memory-side stage result |
| mwb_wr_en | input | 1 | Writeback-side stage will write a register |
| mwb_rd | input | REG_AW | Writeback-side stage destination register |
| mwb_result | input | DATA_W | Writeback-side stage result |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| opnd_a | output | DATA_W | Operand A delivered to the ALU |
| opnd_b | output | DATA_W | Operand B delivered to the ALU |

## Verification
The bench builds the unit with `REG_AW = 3` and `DATA_W = 8`. These values shrink the register space to eight entries, so every combination of both source numbers, both destination numbers and both write flags can be applied, 16384 in all. That full sweep covers every case of zero-register matching, the double-match priority and independence between the two operands. The narrow data path also lets a scoreboard run thousands of randomly chained instructions with dense register reuse, and compare each ALU result against sequential execution.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  // Operand source select codes; the values are decoded by the operand mux.
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10,
    SEL_RSV = 2'b11
  } opnd_sel_e;

  localparam int unsigned NUM_OPNDS = 2;

endpackage

// File: rtl/opfwd_hit.sv
// Decides whether one later pipeline stage can supply a given source register.
module opfwd_hit #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              stg_wr_en,
  input  logic [REG_AW-1:0] stg_rd,
  output logic              hit
);

  logic rd_nonzero;
  logic rd_match;

  always_comb begin
    rd_nonzero = |stg_rd;
    rd_match   = (stg_rd == src);
    hit        = stg_wr_en && rd_nonzero && rd_match;
  end

endmodule

// File: rtl/opfwd_pick.sv
// Per-operand priority: the memory-side stage outranks the writeback-side stage.
module opfwd_pick #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0]     src,
  input  logic                  exm_wr_en,
  input  logic [REG_AW-1:0]     exm_rd,
  input  logic                  mwb_wr_en,
  input  logic [REG_AW-1:0]     mwb_rd,
  output opfwd_pkg::opnd_sel_e  sel
);

  import opfwd_pkg::*;

  logic exm_hit;
  logic mwb_hit;

  opfwd_hit #(.REG_AW(REG_AW)) exm_hit_i (
    .src       (src),
    .stg_wr_en (exm_wr_en),
    .stg_rd    (exm_rd),
    .hit       (exm_hit)
  );

  opfwd_hit #(.REG_AW(REG_AW)) mwb_hit_i (
    .src       (src),
    .stg_wr_en (mwb_wr_en),
    .stg_rd    (mwb_rd),
    .hit       (mwb_hit)
  );

  always_comb begin
    if (exm_hit) begin
      sel = SEL_EXM;
    end else if (mwb_hit) begin
      sel = SEL_MWB;
    end else begin
      sel = SEL_RF;
    end
  end

endmodule

// File: rtl/opfwd_mux.sv
// Operand data mux; the reserved code falls back to the register-file value.
module opfwd_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  opfwd_pkg::opnd_sel_e sel,
  input  logic [DATA_W-1:0]    rf_val,
  input  logic [DATA_W-1:0]    exm_val,
  input  logic [DATA_W-1:0]    mwb_val,
  output logic [DATA_W-1:0]    opnd
);

  import opfwd_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_EXM: opnd = exm_val;
      SEL_MWB: opnd = mwb_val;
      SEL_RF:  opnd = rf_val;
      default: opnd = rf_val;
    endcase
  end

endmodule

// File: rtl/opfwd_unit.sv
// Execute-stage operand forwarding: two independent select/mux lanes.
module opfwd_unit #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic [DATA_W-1:0] rf_val_a,
  input  logic [DATA_W-1:0] rf_val_b,
  input  logic              exm_wr_en,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic [DATA_W-1:0] exm_result,
  input  logic              mwb_wr_en,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic [DATA_W-1:0] mwb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  import opfwd_pkg::*;

  localparam int unsigned LANES = NUM_OPNDS;

  logic [REG_AW-1:0] lane_src [LANES];
  logic [DATA_W-1:0] lane_rf  [LANES];
  opnd_sel_e         lane_sel [LANES];
  logic [DATA_W-1:0] lane_out [LANES];

  always_comb begin
    lane_src[0] = src_a;
    lane_src[1] = src_b;
    lane_rf[0]  = rf_val_a;
    lane_rf[1]  = rf_val_b;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    opfwd_pick #(.REG_AW(REG_AW)) pick_i (
      .src       (lane_src[g]),
      .exm_wr_en (exm_wr_en),
      .exm_rd    (exm_rd),
      .mwb_wr_en (mwb_wr_en),
      .mwb_rd    (mwb_rd),
      .sel       (lane_sel[g])
    );

    opfwd_mux #(.DATA_W(DATA_W)) mux_i (
      .sel     (lane_sel[g]),
      .rf_val  (lane_rf[g]),
      .exm_val (exm_result),
      .mwb_val (mwb_result),
      .opnd    (lane_out[g])
    );
  end

  always_comb begin
    sel_a  = lane_sel[0];
    sel_b  = lane_sel[1];
    opnd_a = lane_out[0];
    opnd_b = lane_out[1];
  end

endmodule

// File: rtl/opfwd_unit_chk.sv
// Port-level checks of the forwarding unit, attached by bind.
module opfwd_unit_chk #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic [REG_AW-1:0] src_a,
  input logic [REG_AW-1:0] src_b,
  input logic [DATA_W-1:0] rf_val_a,
  input logic [DATA_W-1:0] rf_val_b,
  input logic              exm_wr_en,
  input logic [REG_AW-1:0] exm_rd,
  input logic [DATA_W-1:0] exm_result,
  input logic              mwb_wr_en,
  input logic [REG_AW-1:0] mwb_rd,
  input logic [DATA_W-1:0] mwb_result,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);

  logic exm_live;
  logic mwb_live;

  always_comb begin
    exm_live = exm_wr_en && (exm_rd != '0);
    mwb_live = mwb_wr_en && (mwb_rd != '0);

    if (exm_live && exm_rd == src_a) begin
      AST_EXM_FWD_A: assert (sel_a == 2'b10 && opnd_a == exm_result) else $error("exm fwd A"); // R1
    end
    if (exm_live && exm_rd == src_b) begin
      AST_EXM_FWD_B: assert (sel_b == 2'b10 && opnd_b == exm_result) else $error("exm fwd B"); // R2
    end
    if (mwb_live && mwb_rd == src_a && !(exm_live && exm_rd == src_a)) begin
      AST_MWB_FWD_A: assert (sel_a == 2'b01 && opnd_a == mwb_result) else $error("mwb fwd A"); // R3
    end
    if (src_a == '0) begin
      AST_ZERO_REG_A: assert (sel_a == 2'b00 && opnd_a == rf_val_a) else $error("zero A"); // R5
    end
    if (src_b == '0) begin
      AST_ZERO_REG_B: assert (sel_b == 2'b00 && opnd_b == rf_val_b) else $error("zero B"); // R5
    end
    if (!exm_wr_en && !mwb_wr_en) begin
      AST_NO_WRITERS: assert (sel_a == 2'b00 && sel_b == 2'b00) else $error("no writers"); // R6
    end
    AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11) else $error("reserved sel"); // R9
  end

endmodule

bind opfwd_unit opfwd_unit_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) chk_i (
  .src_a      (src_a),
  .src_b      (src_b),
  .rf_val_a   (rf_val_a),
  .rf_val_b   (rf_val_b),
  .exm_wr_en  (exm_wr_en),
  .exm_rd     (exm_rd),
  .exm_result (exm_result),
  .mwb_wr_en  (mwb_wr_en),
  .mwb_rd     (mwb_rd),
  .mwb_result (mwb_result),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b)
);

// File: tb/opfwd_unit_tb_top.sv
module opfwd_unit_tb_top;

  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned SEQ_LEN = 4000;

  logic clk;
  logic rst_n;

  logic [AW-1:0] src_a, src_b, exm_rd, mwb_rd;
  logic [DW-1:0] rf_val_a, rf_val_b, exm_result, mwb_result;
  logic          exm_wr_en, mwb_wr_en;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int n_checks;
  int n_fail;
  bit done;

  opfwd_unit #(.REG_AW(AW), .DATA_W(DW)) dut_i (
    .src_a      (src_a),
    .src_b      (src_b),
    .rf_val_a   (rf_val_a),
    .rf_val_b   (rf_val_b),
    .exm_wr_en  (exm_wr_en),
    .exm_rd     (exm_rd),
    .exm_result (exm_result),
    .mwb_wr_en  (mwb_wr_en),
    .mwb_rd     (mwb_rd),
    .mwb_result (mwb_result),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  // Expected select for one operand, computed from R1..R7.
  function automatic int exp_sel(input int src, input bit xw, input int xrd, input bit mw, input int mrd);
    if (xw && xrd != 0 && xrd == src) return 2;
    if (mw && mrd != 0 && mrd == src) return 1;
    return 0;
  endfunction

  function automatic string tag_for(input int src, input bit xw, input int xrd, input bit mw, input int mrd, input bit is_b);
    bit xm = xw && xrd != 0 && xrd == src;
    bit mm = mw && mrd != 0 && mrd == src;
    if (xm && mm) return "R4";
    if (xm) return is_b ? "R2" : "R1";
    if (mm) return "R3";
    if (src == 0) return "R5";
    if ((xrd == src || mrd == src) && (!xw || !mw)) return "R6";
    return "R7";
  endfunction

  task automatic sweep();
    for (int ra = 0; ra < NREG; ra++) begin
      for (int rb = 0; rb < NREG; rb++) begin
        for (int xd = 0; xd < NREG; xd++) begin
          for (int md = 0; md < NREG; md++) begin
            for (int fl = 0; fl < 4; fl++) begin
              @(negedge clk);
              src_a      = AW'(ra);
              src_b      = AW'(rb);
              rf_val_a   = DW'(8'h10 + ra);
              rf_val_b   = DW'(8'h30 + rb);
              exm_rd     = AW'(xd);
              mwb_rd     = AW'(md);
              exm_wr_en  = fl[1];
              mwb_wr_en  = fl[0];
              exm_result = 8'hA5;
              mwb_result = 8'h5A;
              #2;
              begin
                int sa = exp_sel(ra, fl[1], xd, fl[0], md);
                int sb = exp_sel(rb, fl[1], xd, fl[0], md);
                int va = (sa == 2) ? 8'hA5 : (sa == 1) ? 8'h5A : 8'h10 + ra;
                int vb = (sb == 2) ? 8'hA5 : (sb == 1) ? 8'h5A : 8'h30 + rb;
                string ta = tag_for(ra, fl[1], xd, fl[0], md, 1'b0);
                string tb = tag_for(rb, fl[1], xd, fl[0], md, 1'b1);
                check(int'(sel_a) == sa && int'(opnd_a) == va, ta, {sel_a, opnd_a}, (sa << DW) | va);
                check(int'(sel_b) == sb && int'(opnd_b) == vb, tb, {sel_b, opnd_b}, (sb << DW) | vb);
                // R8: each lane agrees with the formula using only its own source
                check(int'(sel_a) == sa && int'(sel_b) == sb, "R8", {sel_a, sel_b}, (sa << 2) | sb);
                check(sel_a != 2'b11 && sel_b != 2'b11, "R9", {sel_a, sel_b}, 0);
              end
            end
          end
        end
      end
    end
  endtask

  // R10: scoreboard of a 3-deep pipe against sequential execution.
  task automatic run_sequence();
    logic [DW-1:0] rf   [NREG];
    logic [DW-1:0] arch [NREG];
    logic          x_we, m_we;
    logic [AW-1:0] x_rd, m_rd;
    logic [DW-1:0] x_res, m_res;
    for (int i = 0; i < NREG; i++) begin
      rf[i] = '0;
      arch[i] = '0;
    end
    x_we = 1'b0; m_we = 1'b0; x_rd = '0; m_rd = '0; x_res = '0; m_res = '0;
    for (int n = 0; n < SEQ_LEN; n++) begin
      logic [AW-1:0] rs, rt, rd;
      logic          we;
      logic [DW-1:0] gold, alu;
      rs = AW'($urandom % NREG);
      rt = AW'($urandom % NREG);
      rd = AW'($urandom % NREG);
      we = ($urandom % 4) != 0;
      gold = arch[rs] + arch[rt] + 8'd1;
      if (we && rd != '0) arch[rd] = gold;
      @(negedge clk);
      src_a = rs; src_b = rt;
      rf_val_a = rf[rs]; rf_val_b = rf[rt];
      exm_wr_en = x_we; exm_rd = x_rd; exm_result = x_res;
      mwb_wr_en = m_we; mwb_rd = m_rd; mwb_result = m_res;
      #2;
      alu = opnd_a + opnd_b + 8'd1;
      check(alu == gold, "R10", alu, gold);
      if (m_we && m_rd != '0) rf[m_rd] = m_res;
      m_we = x_we; m_rd = x_rd; m_res = x_res;
      x_we = we; x_rd = rd; x_res = alu;
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    src_a = '0; src_b = '0; rf_val_a = 8'h11; rf_val_b = 8'h22;
    exm_wr_en = 1'b0; exm_rd = '0; exm_result = 8'hA5;
    mwb_wr_en = 1'b0; mwb_rd = '0; mwb_result = 8'h5A;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // Idle state: nothing writing, all selects pass the register file (R7)
    check(sel_a == 2'b00 && opnd_a == 8'h11, "R7", {sel_a, opnd_a}, 8'h11);
    check(sel_b == 2'b00 && opnd_b == 8'h22, "R7", {sel_b, opnd_b}, 8'h22);
    sweep();
    run_sequence();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule